// File: doc/BRIEF.md
# Flag Offset Register Programmer

This block fills the two offset registers that place a FIFO's almost-empty and almost-full thresholds. Its outputs are `x_ofs` and `y_ofs`, plus a `done` flag that rises once they hold their final values. The almost flags themselves are computed elsewhere.

The loading method is fixed while master reset is held. It is chosen from a serial/parallel mode pin and two select pins, and there are three methods:

- **Preset:** loads one of three fixed distances into both registers.
- **Parallel:** takes two words from the data bus, X first and then Y.
- **Serial:** shifts a single chained bit stream into Y followed by X. Shifting is gated by an active-low enable and clocked by the port clock.

Once `done` is high, the registers hold their values until the next reset.

The register width is a parameter. The serial bit count is twice that width. The preset values need a width of at least 7 bits.

Top module: `flag_offset_loader`

## Requirements
- R1: While `rst` is high at a rising clock edge, `x_ofs`, `y_ofs` and `done` are cleared to zero, and the loading method is captured from `ser_mode`, `sel_hi` and `sel_lo`.
- R2: Method encoding: `ser_mode`=1 selects serial regardless of the selects. With `ser_mode`=0, {`sel_hi`,`sel_lo`} selects as follows: 00 parallel, 01 preset 8, 10 preset 16, 11 preset 64.
- R3: In a preset method, the first rising edge after reset is released sets both `x_ofs` and `y_ofs` to the preset value and raises `done`.
- R4: In serial mode, each rising edge with `ser_en_n` low shifts `ser_dat` into a 2*OFS_W-bit chain. After 2*OFS_W bits, the first bit sits in the MSB of `y_ofs` and the last bit in the LSB of `x_ofs`. Edges with `ser_en_n` high shift nothing.
- R5: In serial mode, `done` and the final values appear on the edge after the one that takes the last bit; `done` is still low between those two edges.
- R6: In parallel mode, the first edge with `wr_en` high captures `din` for X and the second captures it for Y. Each value appears on the output one edge after its capture, and `done` rises one edge after the second capture.
- R7: Once `done` is high it stays high, and further serial bits and writes leave `x_ofs` and `y_ofs` unchanged until the next reset.
- R8: Inputs of a method that is not selected are ignored: `wr_en` in serial or preset mode, and `ser_en_n` in parallel or preset mode.
- R9: Changing `ser_mode`, `sel_hi` or `sel_lo` after reset is released does not change the method or the values.
- R10: A reset in the middle of a load discards the partial result, and the next load starts from a fresh bit or word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high master reset |
| sel_hi | input | 1 | Method select, upper bit |
| sel_lo | input | 1 | Method select, lower bit |
| ser_mode | input | 1 | High selects serial loading |
| ser_en_n | input | 1 | Active-low serial shift enable |
| ser_dat | input | 1 | Serial data bit |
| wr_en | input | 1 | Parallel write strobe |
| din | input | OFS_W | Parallel offset data |
| x_ofs | output | OFS_W | X (almost-empty) offset |
| y_ofs | output | OFS_W | Y (almost-full) offset |
| done | output | 1 | Programming finished |

## Verification
The bench sweeps every preset code and a dozen serial and parallel value patterns. In each case it computes the expected values from the bit order and the capture order.

It checks `done` in the single cycle before it should rise, so an off-by-one bit counter or an unregistered output shows up as an early or late flag. Bits and writes are driven after `done`, and the other method's strobes are driven during a load. Either would corrupt a design that does not freeze or gate its inputs.

Two further cases target reset handling. The select pins are changed after reset, which catches a decoder that does not latch. A reset is applied halfway through a serial load, which exposes a counter that survives reset.

// File: rtl/flo_pkg.sv
package flo_pkg;

  typedef enum logic [1:0] {
    LM_PRESET   = 2'd0,
    LM_PARALLEL = 2'd1,
    LM_SERIAL   = 2'd2
  } load_mode_e;

  // Preset distance picked by the two select pins (00 is not a preset).
  function automatic logic [6:0] preset_of(input logic [1:0] sel);
    case (sel)
      2'b01:   preset_of = 7'd8;
      2'b10:   preset_of = 7'd16;
      2'b11:   preset_of = 7'd64;
      default: preset_of = 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/flo_method_decode.sv
module flo_method_decode
  import flo_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  logic             ser_mode,
  output load_mode_e       mode,
  output logic [OFS_W-1:0] preset
);

  logic [1:0] sel;
  assign sel = {sel_hi, sel_lo};

  // Method is captured only while reset is held, then frozen.
  always_ff @(posedge clk) begin
    if (rst) begin
      if (ser_mode)
        mode <= LM_SERIAL;
      else if (sel == 2'b00)
        mode <= LM_PARALLEL;
      else
        mode <= LM_PRESET;
      preset <= OFS_W'(preset_of(sel));
    end
  end

endmodule

// File: rtl/flo_serial_chain.sv
module flo_serial_chain #(
  parameter int OFS_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [2*OFS_W-1:0] chain,
  output logic               full
);

  localparam int CHAIN_W = 2 * OFS_W;
  localparam int CNT_W   = $clog2(CHAIN_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_W);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      cnt   <= '0;
    end else if (shift_en && (cnt != LAST)) begin
      chain <= {chain[CHAIN_W-2:0], bit_in};
      cnt   <= cnt + 1'b1;
    end
  end

  assign full = (cnt == LAST);

endmodule

// File: rtl/flo_parallel_load.sv
module flo_parallel_load #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] x_val,
  output logic [OFS_W-1:0] y_val,
  output logic             full
);

  logic got_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_val <= '0;
      y_val <= '0;
      got_x <= 1'b0;
      full  <= 1'b0;
    end else if (wr && !full) begin
      if (!got_x) begin
        x_val <= din;
        got_x <= 1'b1;
      end else begin
        y_val <= din;
        full  <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flo_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_hi,
  input  logic             sel_lo,
  input  logic             ser_mode,
  input  logic             ser_en_n,
  input  logic             ser_dat,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] din,
  output logic [OFS_W-1:0] x_ofs,
  output logic [OFS_W-1:0] y_ofs,
  output logic             done
);

  localparam int CHAIN_W = 2 * OFS_W;

  load_mode_e         mode_q;
  logic [OFS_W-1:0]   preset_q;
  logic [CHAIN_W-1:0] chain;
  logic               ser_full;
  logic [OFS_W-1:0]   par_x;
  logic [OFS_W-1:0]   par_y;
  logic               par_full;
  logic               ser_shift;
  logic               par_wr;

  assign ser_shift = (mode_q == LM_SERIAL) && !ser_en_n;
  assign par_wr    = (mode_q == LM_PARALLEL) && wr_en;

  flo_method_decode #(.OFS_W(OFS_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .sel_hi   (sel_hi),
    .sel_lo   (sel_lo),
    .ser_mode (ser_mode),
    .mode     (mode_q),
    .preset   (preset_q)
  );

  flo_serial_chain #(.OFS_W(OFS_W)) u_ser (
    .clk      (clk),
    .rst      (rst),
    .shift_en (ser_shift),
    .bit_in   (ser_dat),
    .chain    (chain),
    .full     (ser_full)
  );

  flo_parallel_load #(.OFS_W(OFS_W)) u_par (
    .clk   (clk),
    .rst   (rst),
    .wr    (par_wr),
    .din   (din),
    .x_val (par_x),
    .y_val (par_y),
    .full  (par_full)
  );

  // Registered outputs; frozen once done is set.
  always_ff @(posedge clk) begin
    if (rst) begin
      x_ofs <= '0;
      y_ofs <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      case (mode_q)
        LM_PRESET: begin
          x_ofs <= preset_q;
          y_ofs <= preset_q;
          done  <= 1'b1;
        end
        LM_PARALLEL: begin
          x_ofs <= par_x;
          y_ofs <= par_y;
          done  <= par_full;
        end
        LM_SERIAL: begin
          x_ofs <= chain[OFS_W-1:0];
          y_ofs <= chain[CHAIN_W-1:OFS_W];
          done  <= ser_full;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flo_checker.sv
module flo_checker
  import flo_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_en_n,
  input load_mode_e       mode,
  input logic [OFS_W-1:0] x_ofs,
  input logic [OFS_W-1:0] y_ofs,
  input logic             done
);

  localparam int TOTAL = 2 * OFS_W;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] bits_seen;
  logic          rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)
      bits_seen <= '0;
    else if ((mode == LM_SERIAL) && !ser_en_n && (bits_seen < CW'(TOTAL)))
      bits_seen <= bits_seen + 1'b1;
  end

  // R1: a reset edge leaves everything cleared.
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_clear_r1: assert (!done && x_ofs == '0 && y_ofs == '0)
        else $error("reset did not clear outputs");
    end
  end

  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(x_ofs) && $stable(y_ofs)));

  p_serial_count_r4: assert property (@(posedge clk) disable iff (rst)
    ((mode == LM_SERIAL) && done) |-> (bits_seen == CW'(TOTAL)));

  p_preset_equal_r3: assert property (@(posedge clk) disable iff (rst)
    ((mode == LM_PRESET) && done) |-> ((x_ofs == y_ofs) && (x_ofs != '0)));

endmodule

bind flag_offset_loader flo_checker #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_en_n (ser_en_n),
  .mode     (mode_q),
  .x_ofs    (x_ofs),
  .y_ofs    (y_ofs),
  .done     (done)
);

// File: tb/flag_offset_loader_bench.sv
`timescale 1ns/1ps
module flag_offset_loader_bench;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_hi = 1'b0, sel_lo = 1'b0, ser_mode = 1'b0;
  logic         ser_en_n = 1'b1, ser_dat = 1'b0, wr_en = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] x_ofs, y_ofs;
  logic         done;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flag_offset_loader #(.OFS_W(W)) u_flag_offset_loader (
    .clk(clk), .rst(rst), .sel_hi(sel_hi), .sel_lo(sel_lo),
    .ser_mode(ser_mode), .ser_en_n(ser_en_n), .ser_dat(ser_dat),
    .wr_en(wr_en), .din(din), .x_ofs(x_ofs), .y_ofs(y_ofs), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Holds reset for two edges with the given pins; returns at a negedge
  // with reset just released.
  task automatic do_reset(input logic m, input logic [1:0] s);
    @(negedge clk);
    rst = 1'b1; ser_mode = m; sel_hi = s[1]; sel_lo = s[0];
    ser_en_n = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset x", x_ofs, 0);
    check("R1 reset y", y_ofs, 0);
    check("R1 reset done", done, 0);
    rst = 1'b0;
  endtask

  task automatic shift_bits(input logic [W-1:0] yv, input logic [W-1:0] xv,
                            input int nbits, input bit gaps);
    for (int k = 0; k < nbits; k++) begin
      logic b;
      b = (k < W) ? yv[W-1-k] : xv[2*W-1-k];
      if (gaps && k[0]) begin
        ser_en_n = 1'b1; ser_dat = ~b; wr_en = 1'b1;  // R4/R8: no shift
        @(negedge clk);
        wr_en = 1'b0;
      end
      ser_en_n = 1'b0; ser_dat = b;
      @(negedge clk);
    end
    ser_en_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] xv, yv, ex;
    // Preset sweep (R2, R3, R8, R9)
    for (int c = 1; c < 4; c++) begin
      ex = (c == 1) ? 8'd8 : (c == 2) ? 8'd16 : 8'd64;
      do_reset(1'b0, 2'(c));
      @(negedge clk);
      check("R3 preset done", done, 1);
      check("R2 R3 preset x", x_ofs, ex);
      check("R2 R3 preset y", y_ofs, ex);
      ser_mode = 1'b1; sel_hi = 1'b0; sel_lo = 1'b0;  // R9
      wr_en = 1'b1; ser_en_n = 1'b0; din = 8'hFF;     // R8
      repeat (4) @(negedge clk);
      wr_en = 1'b0; ser_en_n = 1'b1;
      @(negedge clk);
      check("R8 R9 preset x held", x_ofs, ex);
      check("R8 R9 preset y held", y_ofs, ex);
    end

    // Serial sweep (R4, R5, R7, R8, R9)
    for (int i = 0; i < 12; i++) begin
      yv = (i == 0) ? 8'h80 : W'(i * 37 + 5);
      xv = (i == 0) ? 8'h01 : W'(i * 91 + 3);
      do_reset(1'b1, 2'b00);
      ser_mode = 1'b0; sel_lo = 1'b1;  // R9: pins move after reset
      shift_bits(yv, xv, 2 * W, i[0]);
      check("R5 done not early", done, 0);
      @(negedge clk);
      check("R5 serial done", done, 1);
      check("R4 serial x", x_ofs, xv);
      check("R4 serial y", y_ofs, yv);
      shift_bits(~yv, ~xv, 5, 1'b0);  // R7
      @(negedge clk);
      check("R7 serial x frozen", x_ofs, xv);
      check("R7 serial y frozen", y_ofs, yv);
    end

    // Parallel sweep (R6, R7, R8)
    for (int i = 0; i < 8; i++) begin
      xv = W'(i * 53 + 17);
      yv = W'(i * 29 + 200);
      do_reset(1'b0, 2'b00);
      ser_en_n = 1'b0; ser_dat = 1'b1;  // R8
      repeat (3) @(negedge clk);
      ser_en_n = 1'b1;
      @(negedge clk);
      check("R8 parallel ignores serial", {x_ofs, y_ofs, 7'd0, done}, 0);
      wr_en = 1'b1; din = xv;
      @(negedge clk);
      wr_en = 1'b0; din = 8'h00;
      @(negedge clk);
      check("R6 parallel x", x_ofs, xv);
      check("R6 done after first", done, 0);
      wr_en = 1'b1; din = yv;
      @(negedge clk);
      wr_en = 1'b0;
      check("R6 done not early", done, 0);
      @(negedge clk);
      check("R6 parallel done", done, 1);
      check("R6 parallel y", y_ofs, yv);
      wr_en = 1'b1; din = ~xv;  // R7
      repeat (2) @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      check("R7 parallel x frozen", x_ofs, xv);
      check("R7 parallel y frozen", y_ofs, yv);
    end

    // Reset in the middle of a serial load (R10)
    do_reset(1'b1, 2'b00);
    shift_bits(8'hFF, 8'hFF, 7, 1'b0);
    do_reset(1'b1, 2'b00);
    shift_bits(8'h3C, 8'hA5, 2 * W, 1'b0);
    check("R10 no early done", done, 0);
    @(negedge clk);
    check("R10 done", done, 1);
    check("R10 x", x_ofs, 8'hA5);
    check("R10 y", y_ofs, 8'h3C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule